// File: doc/BRIEF.md
# Physical Memory Protection Checker

This block guards memory for a small RISC-V style core. It holds a parameterised number of protection regions. Each region has an address register and an 8-bit configuration byte. Software reaches the registers through a simple register port: one write strobe, a select between the configuration byte and the address register, a region index, and a read-back word that is driven combinationally from the same index and select. Writes land on the next rising clock edge.

The check port is purely combinational. It takes the word address of an access (physical address bits XLEN+1:2), the access kind and the privilege level, and returns one fault flag. A region matches as a single naturally aligned 4-byte word or as a naturally aligned power-of-two block. When several regions match, the lowest-numbered one decides. Regions named in a hardwire mask are fixed when the block is elaborated. A granularity parameter sets the smallest region size, restricts which modes can be stored, and shapes how the address registers read back. The check port is an inquiry with no flow to throttle, so it is plain combinational and has no valid/ready handshake. The register port is plain control as well.

Top module: `pmp_checker`

## Requirements
- R1: After reset, every region that is not hardwired reads 0 in its configuration byte and 0 in its address register.
- R2: The configuration byte has read permission in bit 0, write permission in bit 1, execute permission in bit 2, the mode in bits 4:3 (0 off, 1 unsupported, 2 single word, 3 power-of-two block) and lock in bit 7. Bits 5 and 6 always read 0. A write that requests mode 1 stores mode 0.
- R3: When GRAIN is 0, a write that requests mode 2 stores mode 2. When GRAIN is above 0, such a write stores mode 0.
- R4: When GRAIN is 2 or more, the low GRAIN-1 bits of a region's address register read as 0 while its mode is 0 and as 1 while its mode is 3. The block uses the value as read for matching.
- R5: A region marked in HW_MASK reads its configuration from HW_CFG and its address from HW_ADDR. Writes to that region have no effect, and the granularity rules do not apply to it.
- R6: While the lock bit of a region that is not hardwired is set, writes to that region's configuration byte and address register are ignored.
- R7: In mode 2, a region matches exactly the one word whose address equals its address register.
- R8: In mode 3, k trailing ones in the address register give a block of 2^(k+3) bytes. An access matches when its word address equals the register above those k+1 low bits. An all-ones register matches every address.
- R9: When more than one region matches, the lowest-numbered matching region alone decides the result.
- R10: When no region matches, a machine-mode access gets no fault and a user-mode access faults.
- R11: A matching region whose lock bit is clear never faults a machine-mode access. A user-mode access, or any access to a region whose lock bit is set, is checked against that region's permissions.
- R12: The access kind is encoded 0 read, 1 write, 2 execute and 3 reserved. When permissions apply, the block faults if the selected permission bit is clear. Code 3 always faults.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| csr_we | input | 1 | Write strobe for the register port |
| csr_sel_cfg | input | 1 | 1 selects the configuration byte, 0 selects the address register |
| csr_idx | input | IW | Region index for reads and writes |
| csr_wdata | input | XLEN | Write data; bits 7:0 are used for a configuration byte |
| csr_rdata | output | XLEN | Read data for the selected register (configuration is zero-extended) |
| chk_word | input | XLEN | Word address of the access being checked |
| chk_acc | input | 2 | Access kind: 0 read, 1 write, 2 execute, 3 reserved |
| chk_user | input | 1 | 1 for user mode, 0 for machine mode |
| chk_fault | output | 1 | 1 when the access is denied |

## Verification
On every cycle, the assertions check the following. A locked region stays unchanged across a write aimed at it. The reserved configuration bits and the unsupported mode never appear in a region that is not hardwired. The single-word mode is never stored when granularity forbids it. With every region off, the fault equals the user flag. With no lock set, machine mode never faults. Only the bench scenarios can show the rest: the matching sizes, the priority of low-numbered regions over a hardwired catch-all, the read-back forcing of the low address bits, and the reset values, because each of these needs known addresses and expected results.

// File: rtl/pmp_pkg.sv
package pmp_pkg;
  localparam int CFG_R    = 0;
  localparam int CFG_W    = 1;
  localparam int CFG_X    = 2;
  localparam int CFG_A_LO = 3;
  localparam int CFG_A_HI = 4;
  localparam int CFG_L    = 7;
  localparam logic [7:0] CFG_KEEP = 8'h9F;

  typedef enum logic [1:0] {
    MODE_OFF   = 2'd0,
    MODE_TOR   = 2'd1,
    MODE_NA4   = 2'd2,
    MODE_NAPOT = 2'd3
  } mode_e;

  typedef enum logic [1:0] {
    ACC_READ  = 2'd0,
    ACC_WRITE = 2'd1,
    ACC_EXEC  = 2'd2,
    ACC_RSVD  = 2'd3
  } acc_e;
endpackage

// File: rtl/pmp_region_reg.sv
module pmp_region_reg
  import pmp_pkg::*;
#(
  parameter int XLEN  = 32,
  parameter int GRAIN = 0
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_cfg,
  input  logic            wr_addr,
  input  logic [XLEN-1:0] wdata,
  output logic [7:0]      cfg_o,
  output logic [XLEN-1:0] addr_o
);
  localparam bit NA4_OK = (GRAIN == 0);

  logic [7:0]      cfg_q;
  logic [XLEN-1:0] addr_q;
  logic [7:0]      cfg_new;
  logic            locked;

  assign locked = cfg_q[CFG_L];

  always_comb begin
    cfg_new = wdata[7:0] & CFG_KEEP;
    if (cfg_new[CFG_A_HI:CFG_A_LO] == MODE_TOR)
      cfg_new[CFG_A_HI:CFG_A_LO] = MODE_OFF;
    if (!NA4_OK && cfg_new[CFG_A_HI:CFG_A_LO] == MODE_NA4)
      cfg_new[CFG_A_HI:CFG_A_LO] = MODE_OFF;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q  <= '0;
      addr_q <= '0;
    end else if (!locked) begin
      if (wr_cfg)  cfg_q  <= cfg_new;
      if (wr_addr) addr_q <= wdata;
    end
  end

  assign cfg_o = cfg_q;

  if (GRAIN >= 2) begin : g_force
    always_comb begin
      addr_o = addr_q;
      if (cfg_q[CFG_A_HI:CFG_A_LO] == MODE_OFF)
        addr_o[GRAIN-2:0] = '0;
      else if (cfg_q[CFG_A_HI:CFG_A_LO] == MODE_NAPOT)
        addr_o[GRAIN-2:0] = '1;
    end
  end else begin : g_plain
    assign addr_o = addr_q;
  end
endmodule

// File: rtl/pmp_match.sv
module pmp_match
  import pmp_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  logic [1:0]      mode,
  input  logic [XLEN-1:0] region_addr,
  input  logic [XLEN-1:0] word,
  output logic            hit
);
  logic [XLEN-1:0] care;

  // Trailing ones plus the next bit are "don't care" bits.
  assign care = ~(region_addr ^ (region_addr + XLEN'(1)));

  always_comb begin
    unique case (mode)
      MODE_NA4:   hit = (word == region_addr);
      MODE_NAPOT: hit = ((word & care) == (region_addr & care));
      default:    hit = 1'b0;
    endcase
  end
endmodule

// File: rtl/pmp_prio.sv
module pmp_prio #(
  parameter int REGIONS = 4
) (
  input  logic [REGIONS-1:0]   hits,
  input  logic [REGIONS*8-1:0] cfg_flat,
  output logic                 any_hit,
  output logic [7:0]           win_cfg
);
  always_comb begin
    any_hit = 1'b0;
    win_cfg = '0;
    for (int i = REGIONS - 1; i >= 0; i--) begin
      if (hits[i]) begin
        any_hit = 1'b1;
        win_cfg = cfg_flat[i*8 +: 8];
      end
    end
  end
endmodule

// File: rtl/pmp_checker.sv
module pmp_checker
  import pmp_pkg::*;
#(
  parameter int XLEN    = 32,
  parameter int REGIONS = 4,
  parameter int GRAIN   = 0,
  parameter logic [REGIONS-1:0]      HW_MASK = '0,
  parameter logic [REGIONS*XLEN-1:0] HW_ADDR = '0,
  parameter logic [REGIONS*8-1:0]    HW_CFG  = '0,
  localparam int IW = (REGIONS > 1) ? $clog2(REGIONS) : 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            csr_we,
  input  logic            csr_sel_cfg,
  input  logic [IW-1:0]   csr_idx,
  input  logic [XLEN-1:0] csr_wdata,
  output logic [XLEN-1:0] csr_rdata,
  input  logic [XLEN-1:0] chk_word,
  input  logic [1:0]      chk_acc,
  input  logic            chk_user,
  output logic            chk_fault
);
  logic [REGIONS*8-1:0]    cfg_flat;
  logic [REGIONS*XLEN-1:0] addr_flat;
  logic [REGIONS-1:0]      hits;
  logic                    any_hit;
  logic [7:0]              win_cfg;
  logic                    allowed;

  for (genvar i = 0; i < REGIONS; i++) begin : g_reg
    if (HW_MASK[i]) begin : g_hw
      assign cfg_flat[i*8 +: 8]       = HW_CFG[i*8 +: 8];
      assign addr_flat[i*XLEN +: XLEN] = HW_ADDR[i*XLEN +: XLEN];
    end else begin : g_dyn
      logic sel;
      assign sel = csr_we && (csr_idx == IW'(i));
      pmp_region_reg #(.XLEN(XLEN), .GRAIN(GRAIN)) u_reg (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_cfg (sel && csr_sel_cfg),
        .wr_addr(sel && !csr_sel_cfg),
        .wdata  (csr_wdata),
        .cfg_o  (cfg_flat[i*8 +: 8]),
        .addr_o (addr_flat[i*XLEN +: XLEN])
      );
    end

    pmp_match #(.XLEN(XLEN)) u_match (
      .mode       (cfg_flat[i*8+CFG_A_LO +: 2]),
      .region_addr(addr_flat[i*XLEN +: XLEN]),
      .word       (chk_word),
      .hit        (hits[i])
    );
  end

  pmp_prio #(.REGIONS(REGIONS)) u_prio (
    .hits    (hits),
    .cfg_flat(cfg_flat),
    .any_hit (any_hit),
    .win_cfg (win_cfg)
  );

  always_comb begin
    unique case (chk_acc)
      ACC_READ:  allowed = win_cfg[CFG_R];
      ACC_WRITE: allowed = win_cfg[CFG_W];
      ACC_EXEC:  allowed = win_cfg[CFG_X];
      default:   allowed = 1'b0;
    endcase
  end

  assign chk_fault = any_hit ? ((chk_user || win_cfg[CFG_L]) && !allowed)
                             : chk_user;

  always_comb begin
    csr_rdata = '0;
    for (int i = 0; i < REGIONS; i++) begin
      if (csr_idx == IW'(i))
        csr_rdata = csr_sel_cfg ? XLEN'(cfg_flat[i*8 +: 8])
                                : addr_flat[i*XLEN +: XLEN];
    end
  end
endmodule

// File: rtl/pmp_checker_sva.sv
module pmp_checker_sva #(
  parameter int XLEN    = 32,
  parameter int REGIONS = 4,
  parameter int GRAIN   = 0,
  parameter logic [REGIONS-1:0] HW_MASK = '0,
  localparam int IW = (REGIONS > 1) ? $clog2(REGIONS) : 1
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    csr_we,
  input logic [IW-1:0]           csr_idx,
  input logic                    chk_user,
  input logic                    chk_fault,
  input logic [REGIONS*8-1:0]    cfg_flat,
  input logic [REGIONS*XLEN-1:0] addr_flat
);
  logic [REGIONS-1:0] off_v;
  logic [REGIONS-1:0] lock_v;

  for (genvar i = 0; i < REGIONS; i++) begin : g_bits
    assign off_v[i]  = (cfg_flat[i*8+3 +: 2] == 2'd0);
    assign lock_v[i] = cfg_flat[i*8+7];
  end

  for (genvar i = 0; i < REGIONS; i++) begin : g_dyn
    if (!HW_MASK[i]) begin : g_on
      // R6
      lock_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (csr_we && csr_idx == IW'(i) && cfg_flat[i*8+7]) |=>
          ($stable(cfg_flat[i*8 +: 8]) && $stable(addr_flat[i*XLEN +: XLEN])));
      // R2
      rsvd_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_flat[i*8+5 +: 2] == 2'b00) && (cfg_flat[i*8+3 +: 2] != 2'd1));
      if (GRAIN > 0) begin : g_gr
        // R3
        no_na4_chk: assert property (@(posedge clk) disable iff (!rst_n)
          cfg_flat[i*8+3 +: 2] != 2'd2);
      end
    end
  end

  // R10
  all_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (&off_v) |-> (chk_fault == chk_user));

  // R11
  mach_free_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (lock_v == '0 && !chk_user) |-> !chk_fault);
endmodule

bind pmp_checker pmp_checker_sva #(
  .XLEN(XLEN), .REGIONS(REGIONS), .GRAIN(GRAIN), .HW_MASK(HW_MASK)
) u_sva (
  .clk      (clk),
  .rst_n    (rst_n),
  .csr_we   (csr_we),
  .csr_idx  (csr_idx),
  .chk_user (chk_user),
  .chk_fault(chk_fault),
  .cfg_flat (cfg_flat),
  .addr_flat(addr_flat)
);

// File: tb/pmp_checker_bench.sv
module pmp_checker_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        we_a = 1'b0, we_b = 1'b0;
  logic        sel_cfg = 1'b0;
  logic [1:0]  idx = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata_a, rdata_b;
  logic [31:0] word = '0;
  logic [1:0]  acc = '0;
  logic        user = 1'b0;
  logic        fault_a, fault_b;
  int n_cmp = 0, n_bad = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  pmp_checker #(
    .XLEN(32), .REGIONS(4), .GRAIN(0), .HW_MASK(4'b1000),
    .HW_ADDR({32'hFFFF_FFFF, 96'h0}), .HW_CFG({8'h19, 24'h0})
  ) u_pmp_checker (
    .clk(clk), .rst_n(rst_n), .csr_we(we_a), .csr_sel_cfg(sel_cfg),
    .csr_idx(idx), .csr_wdata(wdata), .csr_rdata(rdata_a),
    .chk_word(word), .chk_acc(acc), .chk_user(user), .chk_fault(fault_a)
  );

  pmp_checker #(.XLEN(32), .REGIONS(4), .GRAIN(2)) u_pmp_checker_g2 (
    .clk(clk), .rst_n(rst_n), .csr_we(we_b), .csr_sel_cfg(sel_cfg),
    .csr_idx(idx), .csr_wdata(wdata), .csr_rdata(rdata_b),
    .chk_word(word), .chk_acc(acc), .chk_user(user), .chk_fault(fault_b)
  );

  // {word[35:4], acc[3:2], user[1], expected fault[0]}
  localparam logic [35:0] VEC [15] = '{
    {32'h0000_0400, 2'd0, 1'b1, 1'b0},
    {32'h0000_0400, 2'd1, 1'b1, 1'b0},
    {32'h0000_0400, 2'd2, 1'b1, 1'b1},
    {32'h0000_0401, 2'd1, 1'b1, 1'b1},
    {32'h0000_0401, 2'd0, 1'b1, 1'b0},
    {32'h0000_0800, 2'd2, 1'b1, 1'b0},
    {32'h0000_083F, 2'd2, 1'b1, 1'b0},
    {32'h0000_0840, 2'd2, 1'b1, 1'b1},
    {32'h0000_0820, 2'd0, 1'b1, 1'b1},
    {32'h0000_0820, 2'd0, 1'b0, 1'b1},
    {32'h0000_0400, 2'd2, 1'b0, 1'b0},
    {32'h0000_1400, 2'd1, 1'b0, 1'b0},
    {32'h0000_07FF, 2'd0, 1'b1, 1'b0},
    {32'h0000_1400, 2'd3, 1'b1, 1'b1},
    {32'h0000_03FF, 2'd1, 1'b1, 1'b1}
  };
  string TAG [15] = '{"R7 R12", "R7 R12", "R12", "R7 R9", "R9", "R8", "R8",
                      "R8 R9", "R9", "R11", "R11", "R11", "R8", "R12", "R9"};

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input bit b, input bit c, input int i, input logic [31:0] d);
    @(negedge clk);
    sel_cfg = c; idx = 2'(i); wdata = d;
    if (b) we_b = 1'b1; else we_a = 1'b1;
    @(posedge clk); #1;
    we_a = 1'b0; we_b = 1'b0;
  endtask

  task automatic rd(input bit b, input bit c, input int i, input string req,
                    input logic [31:0] exp);
    @(negedge clk);
    sel_cfg = c; idx = 2'(i);
    #1 check(req, b ? rdata_b : rdata_a, exp);
  endtask

  task automatic probe(input bit b, input logic [31:0] w, input logic [1:0] a,
                       input bit u, input string req, input bit exp);
    @(negedge clk);
    word = w; acc = a; user = u;
    #1 check(req, 32'(b ? fault_b : fault_a), 32'(exp));
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_bad++; n_cmp++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    rd(0, 1, 0, "R1 cfg0", 32'h0);
    rd(0, 0, 0, "R1 addr0", 32'h0);
    rd(1, 1, 2, "R1 g2 cfg2", 32'h0);
    rd(0, 1, 3, "R5 hw cfg", 32'h19);
    rd(0, 0, 3, "R5 hw addr", 32'hFFFF_FFFF);
    probe(0, 32'h400, 2'd0, 1, "R9 hw catch-all read", 0);
    probe(0, 32'h400, 2'd1, 1, "R12 hw catch-all write", 1);
    probe(0, 32'h400, 2'd1, 0, "R11 unlocked machine", 0);
    probe(1, 32'h400, 2'd0, 1, "R10 no match user", 1);
    probe(1, 32'h400, 2'd1, 0, "R10 no match machine", 0);

    // Program the main instance: region 0 single word, region 1 256-byte block.
    wr(0, 0, 0, 32'h400);
    wr(0, 1, 0, 32'h13);
    wr(0, 0, 1, 32'h81F);
    wr(0, 1, 1, 32'h9C);
    rd(0, 1, 0, "R3 G=0 keeps NA4", 32'h13);

    for (int k = 0; k < 15; k++)
      probe(0, VEC[k][35:4], VEC[k][3:2], VEC[k][1], TAG[k], VEC[k][0]);

    wr(0, 0, 1, 32'h0);
    wr(0, 1, 1, 32'h0);
    rd(0, 0, 1, "R6 locked addr", 32'h81F);
    rd(0, 1, 1, "R6 locked cfg", 32'h9C);
    wr(0, 1, 3, 32'h0);
    wr(0, 0, 3, 32'h0);
    rd(0, 1, 3, "R5 hw cfg after write", 32'h19);
    rd(0, 0, 3, "R5 hw addr after write", 32'hFFFF_FFFF);
    wr(0, 1, 2, 32'h60);
    rd(0, 1, 2, "R2 reserved bits", 32'h0);
    wr(0, 1, 2, 32'h08);
    rd(0, 1, 2, "R2 mode 1 to off", 32'h0);

    // Granularity 2 instance.
    wr(1, 1, 0, 32'h13);
    rd(1, 1, 0, "R3 G>0 NA4 to off", 32'h03);
    wr(1, 0, 0, 32'h401);
    rd(1, 0, 0, "R4 off low bit 0", 32'h400);
    wr(1, 1, 0, 32'h1B);
    rd(1, 0, 0, "R4 napot low bit 1", 32'h401);
    wr(1, 0, 0, 32'h400);
    rd(1, 0, 0, "R4 napot forced", 32'h401);
    probe(1, 32'h403, 2'd1, 1, "R4 R8 16-byte top", 0);
    probe(1, 32'h404, 2'd1, 1, "R8 past block", 1);
    probe(1, 32'h3FF, 2'd1, 1, "R8 below block", 1);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule